// File: doc/BRIEF.md
# Pseudo-SRAM Power and Sleep Sequencer

This block owns the three power-related control pins of a pseudo-SRAM: the secondary chip enable, the program-enable strobe and the right to hold the primary chip enable inactive. After the supply is good it holds the secondary enable low for a microsecond-scale interval. It then raises that enable while keeping the primary enable parked high for a long recovery hold. Only after that hold does it raise `ready_o`, which the access controller uses as its gate.

From the ready state a host may put the memory into deep power-down and later wake it. Before any regular access, the host may also run the one-time power-down mode programming step. That step drives a key on the upper address lines and pulses program-enable low. Microsecond holds are counted with a prescaler on the system clock. Nanosecond holds are counted directly in clock cycles. `ready_o` is low during every sequence.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is high or `pwr_good` is low, the outputs are `ce2_o`=0, `ce1_park_o`=1, `pe_n_o`=1, `key_oe_o`=0, `key_o`=0, `ready_o`=0 and `pgm_err_o`=0.
- R2: After the first edge that samples `pwr_good` high, `ce2_o` stays low for exactly LOW_US*PRESCALE cycles. It then goes high with `ce1_park_o` high for exactly HIGH_US*PRESCALE cycles, after which `ready_o` rises.
- R3: `ce1_park_o` is already high in the cycle `ce2_o` rises. `ready_o` is 1 only with `ce2_o`=1, `ce1_park_o`=0, `pe_n_o`=1 and `key_oe_o`=0, and it is 0 in every sequence state.
- R4: A `sleep_req` sampled in ready with `acc_idle`=1 starts this sequence. First `ce1_park_o` goes high and `ce2_o` stays high for PD_SETUP_CYC cycles. Then `ce2_o` goes low for at least PD_LOW_CYC cycles, and a `wake_req` during these two phases has no effect.
- R5: A `sleep_req` sampled while `acc_idle`=0 is ignored and `ready_o` stays 1.
- R6: A `wake_req` sampled after the low hold has ended raises `ce2_o` with `ce1_park_o` high for HIGH_US*PRESCALE cycles, and then `ready_o` returns.
- R7: An accepted `pgm_req` captures `pgm_key` and runs three phases. The key is driven (`key_oe_o`=1, `key_o`=key) with `ce2_o` and `ce1_park_o` high for PGM_SETUP_CYC cycles. Then `pe_n_o`=0 for PGM_PULSE_CYC cycles. Then `pe_n_o`=1 with the key still driven for PGM_HOLD_CYC cycles, after which the block returns to ready.
- R8: Programming runs at most once per power-up. A later `pgm_req` in ready gives a one-cycle `pgm_err_o` in the next cycle and leaves the block in ready.
- R9: A `pgm_req` in ready is rejected with a one-cycle `pgm_err_o` once `acc_start` has been seen since power-up. This includes an `acc_start` in the same cycle as the request.
- R10: When `pgm_req` and `sleep_req` arrive in the same ready cycle, an accepted program wins and the sleep request is dropped. A rejected program still signals `pgm_err_o`, and the sleep request proceeds if `acc_idle`=1.
- R11: A `pwr_good` sampled low forces the R1 output state in the next cycle from any state. It also clears the access and program history, so the next power-up repeats R2 and may program again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply has reached its minimum level |
| sleep_req | input | 1 | Host request to enter deep power-down |
| wake_req | input | 1 | Host request to leave deep power-down |
| pgm_req | input | 1 | Host request for the one-time mode programming step |
| pgm_key | input | KEY_W | Key to place on the upper address lines while programming |
| acc_idle | input | 1 | Access controller has no cycle in flight |
| acc_start | input | 1 | Access controller began a regular read or write |
| ce2_o | output | 1 | Secondary chip enable, active high |
| ce1_park_o | output | 1 | Access path must hold the primary chip enable inactive (high) |
| pe_n_o | output | 1 | Program-enable strobe, active low |
| key_oe_o | output | 1 | Upper address lines carry `key_o` instead of the access address |
| key_o | output | KEY_W | Programming key value, zero when not driven |
| ready_o | output | 1 | Memory may be accessed |
| pgm_err_o | output | 1 | One-cycle pulse: programming request refused |

## Verification
Two functions can fall into the same ready cycle: the programming request with its refusal check, and sleep entry. A further case is the recording of an access that makes a request too late. The bench first issues `pgm_req` and `sleep_req` together on a fresh power-up and expects the key to be driven while the sleep request is lost. After a power cycle it issues `acc_start`, `pgm_req` and `sleep_req` in one cycle with the controller idle. There it expects an error pulse in the same cycle that `ready_o` falls and the sleep setup phase begins. A behavioural model with per-phase countdowns judges every output on every cycle, and targeted checks name each coincidence.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PU_LOW,
    ST_RECOVER,
    ST_READY,
    ST_SLP_SETUP,
    ST_SLP_ENTER,
    ST_ASLEEP,
    ST_KEY_SETUP,
    ST_KEY_PULSE,
    ST_KEY_HOLD
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_tick_gen.sv
module psram_tick_gen #(
  parameter int PRESCALE = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] RELOAD = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart)      pre_q <= RELOAD;
    else if (pre_q == '0)    pre_q <= RELOAD;
    else                     pre_q <= pre_q - 1'b1;
  end

  assign tick = (pre_q == '0);
endmodule

// File: rtl/psram_hold_timer.sv
module psram_hold_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (step && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = step && (cnt_q == '0);
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_seq_pkg::*;
#(
  parameter int PRESCALE      = 200,
  parameter int LOW_US        = 50,
  parameter int HIGH_US       = 350,
  parameter int PD_SETUP_CYC  = 2,
  parameter int PD_LOW_CYC    = 14,
  parameter int PGM_SETUP_CYC = 14,
  parameter int PGM_PULSE_CYC = 14,
  parameter int PGM_HOLD_CYC  = 2,
  parameter int KEY_W         = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             pgm_req,
  input  logic [KEY_W-1:0] pgm_key,
  input  logic             acc_idle,
  input  logic             acc_start,
  output logic             ce2_o,
  output logic             ce1_park_o,
  output logic             pe_n_o,
  output logic             key_oe_o,
  output logic [KEY_W-1:0] key_o,
  output logic             ready_o,
  output logic             pgm_err_o
);
  localparam int MAX_US  = max_of(LOW_US, HIGH_US);
  localparam int MAX_CYC = max_of(max_of(PD_SETUP_CYC, PD_LOW_CYC),
                                  max_of(max_of(PGM_SETUP_CYC, PGM_PULSE_CYC), PGM_HOLD_CYC));
  localparam int CW      = $clog2(max_of(MAX_US, MAX_CYC) + 1);

  seq_state_e    state_q, state_d;
  logic          spent_q;
  logic          pgm_ok, pgm_rej;
  logic          tmr_load, tmr_step, tmr_done, us_tick, us_mode;
  logic [CW-1:0] tmr_val;
  logic [KEY_W-1:0] key_q;

  // ---------------- timing resources ----------------
  assign tmr_load = (state_d != state_q);
  assign us_mode  = (state_q == ST_PU_LOW) || (state_q == ST_RECOVER);
  assign tmr_step = us_mode ? us_tick : 1'b1;

  always_comb begin
    unique case (state_d)
      ST_PU_LOW:    tmr_val = CW'(LOW_US - 1);
      ST_RECOVER:   tmr_val = CW'(HIGH_US - 1);
      ST_SLP_SETUP: tmr_val = CW'(PD_SETUP_CYC - 1);
      ST_SLP_ENTER: tmr_val = CW'(PD_LOW_CYC - 1);
      ST_KEY_SETUP: tmr_val = CW'(PGM_SETUP_CYC - 1);
      ST_KEY_PULSE: tmr_val = CW'(PGM_PULSE_CYC - 1);
      ST_KEY_HOLD:  tmr_val = CW'(PGM_HOLD_CYC - 1);
      default:      tmr_val = '0;
    endcase
  end

  psram_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .restart(tmr_load), .tick(us_tick)
  );

  psram_hold_timer #(.CW(CW)) u_hold (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .step(tmr_step), .done(tmr_done)
  );

  // ---------------- sequencing ----------------
  always_comb begin
    state_d = state_q;
    pgm_ok  = 1'b0;
    pgm_rej = 1'b0;
    if (!pwr_good) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:       state_d = ST_PU_LOW;
        ST_PU_LOW:    if (tmr_done) state_d = ST_RECOVER;
        ST_RECOVER:   if (tmr_done) state_d = ST_READY;
        ST_READY: begin
          if (pgm_req) begin
            if (spent_q || acc_start) pgm_rej = 1'b1;
            else begin
              pgm_ok  = 1'b1;
              state_d = ST_KEY_SETUP;
            end
          end
          if (!pgm_ok && sleep_req && acc_idle) state_d = ST_SLP_SETUP;
        end
        ST_SLP_SETUP: if (tmr_done) state_d = ST_SLP_ENTER;
        ST_SLP_ENTER: if (tmr_done) state_d = ST_ASLEEP;
        ST_ASLEEP:    if (wake_req) state_d = ST_RECOVER;
        ST_KEY_SETUP: if (tmr_done) state_d = ST_KEY_PULSE;
        ST_KEY_PULSE: if (tmr_done) state_d = ST_KEY_HOLD;
        ST_KEY_HOLD:  if (tmr_done) state_d = ST_READY;
        default:      state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      spent_q    <= 1'b0;
      key_q      <= '0;
      ce2_o      <= 1'b0;
      ce1_park_o <= 1'b1;
      pe_n_o     <= 1'b1;
      key_oe_o   <= 1'b0;
      ready_o    <= 1'b0;
      pgm_err_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      spent_q    <= pwr_good && (spent_q || acc_start || pgm_ok);
      if (pgm_ok) key_q <= pgm_key;
      ce2_o      <= (state_d == ST_RECOVER) || (state_d == ST_READY) ||
                    (state_d == ST_SLP_SETUP) || (state_d == ST_KEY_SETUP) ||
                    (state_d == ST_KEY_PULSE) || (state_d == ST_KEY_HOLD);
      ce1_park_o <= (state_d != ST_READY);
      pe_n_o     <= (state_d != ST_KEY_PULSE);
      key_oe_o   <= (state_d == ST_KEY_SETUP) || (state_d == ST_KEY_PULSE) ||
                    (state_d == ST_KEY_HOLD);
      ready_o    <= (state_d == ST_READY);
      pgm_err_o  <= pgm_rej;
    end
  end

  assign key_o = key_oe_o ? key_q : '0;

  // ---------------- checks ----------------
  logic pulse_seen_q, acc_seen_q;
  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      pulse_seen_q <= 1'b0;
      acc_seen_q   <= 1'b0;
    end else begin
      if (!pe_n_o)   pulse_seen_q <= 1'b1;
      if (acc_start) acc_seen_q   <= 1'b1;
    end
  end

  p_ce1_leads_ce2_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ce2_o) |-> ce1_park_o);

  p_ready_clean_r3: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (ce2_o && !ce1_park_o && pe_n_o && !key_oe_o));

  p_pd_setup_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(ce2_o) && $past(pwr_good)) |-> ($past(ce1_park_o) && $past(ce2_o)));

  p_pe_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !pe_n_o |-> (ce2_o && ce1_park_o && key_oe_o));

  p_one_key_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(pe_n_o) |-> !pulse_seen_q);

  p_no_key_after_access_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(key_oe_o) |-> !acc_seen_q);

  p_power_loss_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_good) |-> (!ce2_o && ce1_park_o && !ready_o && pe_n_o));
endmodule

// File: tb/psram_pwr_seq_tb_top.sv
module psram_pwr_seq_tb_top;
  localparam int PRE = 3, LUS = 4, HUS = 5, PDS = 2, PDL = 6, PGS = 3, PGP = 4, PGH = 2, KW = 5;
  localparam int PH_OFF = 0, PH_LOW = 1, PH_REC = 2, PH_RDY = 3, PH_DS = 4, PH_DL = 5,
                 PH_SLP = 6, PH_KS = 7, PH_KP = 8, PH_KH = 9;

  logic clk = 1'b0, rst = 1'b1;
  logic pwr_good = 0, sleep_req = 0, wake_req = 0, pgm_req = 0, acc_idle = 1, acc_start = 0;
  logic [KW-1:0] pgm_key = '0;
  logic ce2_o, ce1_park_o, pe_n_o, key_oe_o, ready_o, pgm_err_o;
  logic [KW-1:0] key_o;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  psram_pwr_seq #(.PRESCALE(PRE), .LOW_US(LUS), .HIGH_US(HUS), .PD_SETUP_CYC(PDS),
    .PD_LOW_CYC(PDL), .PGM_SETUP_CYC(PGS), .PGM_PULSE_CYC(PGP), .PGM_HOLD_CYC(PGH),
    .KEY_W(KW)) dut_i (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .sleep_req(sleep_req), .wake_req(wake_req),
    .pgm_req(pgm_req), .pgm_key(pgm_key), .acc_idle(acc_idle), .acc_start(acc_start),
    .ce2_o(ce2_o), .ce1_park_o(ce1_park_o), .pe_n_o(pe_n_o), .key_oe_o(key_oe_o),
    .key_o(key_o), .ready_o(ready_o), .pgm_err_o(pgm_err_o));

  // behavioural reference: phase plus remaining cycles
  int ph = PH_OFF, left = 0;
  bit spent = 0, m_err = 0;
  logic [KW-1:0] m_key = '0;

  always @(posedge clk) begin
    if (rst || !pwr_good) begin
      ph <= PH_OFF; spent <= 0; m_err <= 0; left <= 0;
      if (rst) m_key <= '0;
    end else begin
      m_err <= 0;
      spent <= spent | acc_start;
      case (ph)
        PH_OFF: begin ph <= PH_LOW; left <= LUS * PRE; end
        PH_LOW: if (left == 1) begin ph <= PH_REC; left <= HUS * PRE; end else left <= left - 1;
        PH_REC: if (left == 1) ph <= PH_RDY; else left <= left - 1;
        PH_RDY: begin
          if (pgm_req && !spent && !acc_start) begin
            ph <= PH_KS; left <= PGS; m_key <= pgm_key; spent <= 1;
          end else begin
            if (pgm_req) m_err <= 1;
            if (sleep_req && acc_idle) begin ph <= PH_DS; left <= PDS; end
          end
        end
        PH_DS: if (left == 1) begin ph <= PH_DL; left <= PDL; end else left <= left - 1;
        PH_DL: if (left == 1) ph <= PH_SLP; else left <= left - 1;
        PH_SLP: if (wake_req) begin ph <= PH_REC; left <= HUS * PRE; end
        PH_KS: if (left == 1) begin ph <= PH_KP; left <= PGP; end else left <= left - 1;
        PH_KP: if (left == 1) begin ph <= PH_KH; left <= PGH; end else left <= left - 1;
        PH_KH: if (left == 1) ph <= PH_RDY; else left <= left - 1;
        default: ph <= PH_OFF;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic string tag_of(input int p);
    case (p)
      PH_OFF: return "R1";
      PH_LOW, PH_REC: return "R2";
      PH_RDY: return "R3";
      PH_DS, PH_DL: return "R4";
      PH_SLP: return "R6";
      default: return "R7";
    endcase
  endfunction

  // compare every output against the model away from the clock edge
  always @(negedge clk) if (!rst) begin
    automatic bit e_ce2  = ph inside {PH_REC, PH_RDY, PH_DS, PH_KS, PH_KP, PH_KH};
    automatic bit e_park = (ph != PH_RDY);
    automatic bit e_pe   = (ph != PH_KP);
    automatic bit e_koe  = ph inside {PH_KS, PH_KP, PH_KH};
    automatic string t   = tag_of(ph);
    chk(ce2_o == e_ce2, {t, " ce2"}, ce2_o, e_ce2);
    chk(ce1_park_o == e_park, {t, " park"}, ce1_park_o, e_park);
    chk(pe_n_o == e_pe, {t, " pe_n"}, pe_n_o, e_pe);
    chk(key_oe_o == e_koe, {t, " key_oe"}, key_oe_o, e_koe);
    chk(key_o == (e_koe ? m_key : '0), {t, " key"}, key_o, e_koe ? m_key : 0);
    chk(ready_o == (ph == PH_RDY), "R3 ready", ready_o, ph == PH_RDY);
    chk(pgm_err_o == m_err, "R8 R9 err", pgm_err_o, m_err);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(input string tag);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ready_o) return;
    end
    chk(0, {tag, " ready timeout"}, 0, 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    cyc(3); rst = 0;
    cyc(5);
    chk(!ce2_o && ce1_park_o && pe_n_o && !ready_o && !pgm_err_o, "R1 idle before power", ce2_o, 0);
    pwr_good = 1;
    wait_ready("R2");
    // R5: sleep refused while access path busy
    acc_idle = 0; sleep_req = 1; cyc(1); sleep_req = 0;
    cyc(1); chk(ready_o == 1, "R5 busy sleep ignored", ready_o, 1);
    acc_idle = 1; cyc(2);
    // R10: program and sleep together on fresh power-up, program wins
    pgm_key = 5'h15; pgm_req = 1; sleep_req = 1; cyc(1); pgm_req = 0; sleep_req = 0;
    chk(key_oe_o && ce2_o && !ready_o, "R10 program wins", key_oe_o, 1);
    chk(key_o == 5'h15, "R7 key value", key_o, 5'h15);
    wait_ready("R7");
    // R8: second programming refused
    pgm_key = 5'h0a; pgm_req = 1; cyc(1); pgm_req = 0;
    chk(pgm_err_o && ready_o, "R8 second program refused", pgm_err_o, 1);
    cyc(1); chk(!pgm_err_o, "R8 error is one cycle", pgm_err_o, 0);
    // R11: power loss
    pwr_good = 0; cyc(1);
    chk(!ce2_o && ce1_park_o && !ready_o, "R11 power loss", ce2_o, 0);
    cyc(3); pwr_good = 1;
    wait_ready("R11 repowered");
    // R9 + R10: access, program and sleep coincide
    acc_start = 1; pgm_req = 1; sleep_req = 1; cyc(1);
    acc_start = 0; pgm_req = 0; sleep_req = 0;
    chk(pgm_err_o && !ready_o && !key_oe_o && ce2_o && ce1_park_o, "R9 R10 coincident refusal", pgm_err_o, 1);
    // R4: early wake ignored during setup and low hold
    wake_req = 1; cyc(PDS + 2); wake_req = 0;
    cyc(PDL);
    chk(!ce2_o && !ready_o, "R4 early wake ignored", ce2_o, 0);
    cyc(4);
    // R6: wake
    wake_req = 1; cyc(1); wake_req = 0;
    chk(ce2_o && ce1_park_o, "R6 wake recovery", ce2_o, 1);
    wait_ready("R6");
    // R9: access seen earlier, later request refused
    acc_start = 1; cyc(1); acc_start = 0; cyc(2);
    pgm_req = 1; cyc(1); pgm_req = 0;
    chk(pgm_err_o && ready_o, "R9 refused after access", pgm_err_o, 1);
    cyc(3);
    summary();
  end
endmodule